// File: doc/BRIEF.md
# Polyphase Decimate-by-Four FIR Filter

This block filters a stream of signed samples with a sixteen-tap FIR response and keeps one result out of every four. It does not compute all sixteen products per input. Four multiply-accumulate stages are chained instead, and each stage owns a contiguous group of four coefficients. Each stage steps through its group once per four-sample frame. At the start of a frame a stage seeds its accumulator from the stage before it, and for the rest of the frame it adds to its own running sum. The sample stream reaches each stage through a shift-register tap, with a skew of two frames per stage. That skew makes each stage work on the same output frame one frame after its upstream neighbour.

Coefficients are written one tap at a time through an address/data port while no samples are being accepted. The full-precision 40-bit result leaves the last stage. A one-cycle valid strobe marks it in the clock after the input that closes a frame. The result carries the output for the frame that ended three frames earlier, so the fixed latency is (STAGES-1)×DECIM accepted samples plus one clock. Reset clears the delay line, the accumulators and the frame phase. The coefficients keep their values across reset.

Top module: `poly_decim_fir`

## Requirements
- R1: Every emitted value equals y[n] = Σ_{k=0..15} h[k]·x[n−k], computed at full precision with signed 16-bit samples and signed 18-bit coefficients, where x[i] is the i-th accepted sample since reset and x[i]=0 for i<0.
- R2: `outValid` is high for exactly one clock, in the cycle right after the accepted sample whose index since reset i satisfies i mod 4 = 3. No other accepted sample produces an output.
- R3: The output strobed after accepted sample i (i mod 4 = 3) carries y[i−12]. The first three outputs after reset are therefore zero.
- R4: In a cycle with `inValid` low, the frame phase does not advance, `outValid` stays low and `outData` keeps its value.
- R5: Asserting `coefWe` with address a (0..15) and data d sets h[a]=d, with address a being tap k=a of R1. Writes are made only while `inValid` is low, and the bench makes them directly after reset.
- R6: After reset `outValid` is 0 and `outData` is 0. Processing then continues as if all earlier samples were zero, with the coefficients unchanged.
- R7: When `inValid` is held high, `outValid` is never high in two consecutive clocks.
- R8: With every sample at −32768 and every coefficient at −131072, the output reaches +2^36 without wrapping in the 40-bit accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Sample on `inSample` is accepted this clock |
| inSample | input | 16 | Signed input sample |
| coefWe | input | 1 | Coefficient write enable |
| coefAddr | input | 4 | Tap index to write |
| coefData | input | 18 | Signed coefficient value |
| outValid | output | 1 | One-clock strobe for a new decimated result |
| outData | output | 40 | Signed full-precision filter output |

## Verification
The bench builds the block with its default parameters: 16-bit samples, 18-bit coefficients, decimation by four, four stages and a 40-bit accumulator. With these values the full 24-sample skew chain and the three-frame cascade latency are exercised, so outputs right after reset, and again after a reset in the middle of a stream, are compared with a zero-history convolution. These widths also let the most negative sample times the most negative coefficient, summed sixteen times, test the accumulator headroom at 2^36. Streams both with idle gaps and with continuous valid check the frame phase against the sample count.

// File: rtl/decim_fir_pkg.sv
package decim_fir_pkg;

  // Strobes handed from the frame controller to the MAC datapath.
  typedef struct packed {
    logic advance;   // a sample is accepted this clock
    logic load;      // first sample of a frame: seed from upstream stage
    logic frameEnd;  // last sample of a frame
  } mac_ctrl_t;

endpackage

// File: rtl/decim_fir_ctrl.sv
module decim_fir_ctrl
  import decim_fir_pkg::*;
#(
  parameter int DECIM   = 4,
  parameter int PHASE_W = (DECIM > 1) ? $clog2(DECIM) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  output mac_ctrl_t          strobes,
  output logic [PHASE_W-1:0] phase
);

  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(DECIM - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (inValid) begin
      phase <= (phase == LAST_PHASE) ? '0 : phase + 1'b1;
    end
  end

  always_comb begin
    strobes.advance  = inValid;
    strobes.load     = (phase == '0);
    strobes.frameEnd = (phase == LAST_PHASE);
  end

  // R4: the phase only moves on accepted samples
  assert_phase_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(phase));

  // R2: a frame closes after exactly DECIM accepted samples
  assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (inValid && phase == LAST_PHASE) |=> (phase == '0));

endmodule

// File: rtl/decim_fir_dp.sv
module decim_fir_dp
  import decim_fir_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int COEF_W  = 18,
  parameter int DECIM   = 4,
  parameter int STAGES  = 4,
  parameter int ACC_W   = 40,
  parameter int PHASE_W = (DECIM > 1) ? $clog2(DECIM) : 1,
  parameter int ADDR_W  = $clog2(DECIM * STAGES)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  mac_ctrl_t                strobes,
  input  logic [PHASE_W-1:0]       phase,
  input  logic signed [DATA_W-1:0] inSample,
  input  logic                     coefWe,
  input  logic [ADDR_W-1:0]        coefAddr,
  input  logic signed [COEF_W-1:0] coefData,
  output logic                     outValid,
  output logic signed [ACC_W-1:0]  outData
);

  localparam int TAPS   = DECIM * STAGES;
  localparam int PROD_W = DATA_W + COEF_W;
  localparam int SKEW   = 2 * DECIM;            // samples between stages
  localparam int HIST   = SKEW * (STAGES - 1);
  localparam int HIST_D = (HIST > 0) ? HIST : 1;

  logic signed [COEF_W-1:0] coefMem [TAPS];
  logic signed [DATA_W-1:0] histLine [HIST_D];
  logic signed [ACC_W-1:0]  accBus [STAGES];

  // Coefficient store, written while the stream is idle.
  always_ff @(posedge clk) begin
    if (coefWe) coefMem[coefAddr] <= coefData;
  end

  // Sample history; histLine[i] holds the sample accepted i+1 samples ago.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < HIST_D; i++) histLine[i] <= '0;
    end else if (strobes.advance) begin
      histLine[0] <= inSample;
      for (int i = 1; i < HIST_D; i++) histLine[i] <= histLine[i-1];
    end
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic signed [DATA_W-1:0] stageSample;
    logic signed [ACC_W-1:0]  cascadeIn;
    logic [ADDR_W-1:0]        tapIdx;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  accReg;

    if (s == 0) begin : g_head
      assign stageSample = inSample;
      assign cascadeIn   = '0;
    end else begin : g_tail
      assign stageSample = histLine[SKEW*s-1];
      assign cascadeIn   = accBus[s-1];
    end

    // Phase 0 uses the highest tap of the group, the closing phase the lowest.
    assign tapIdx = ADDR_W'(s*DECIM + DECIM - 1) - ADDR_W'(phase);
    assign prod   = PROD_W'(stageSample) * PROD_W'(coefMem[tapIdx]);

    always_ff @(posedge clk) begin
      if (rst) begin
        accReg <= '0;
      end else if (strobes.advance) begin
        accReg <= (strobes.load ? cascadeIn : accReg) + ACC_W'(prod);
      end
    end

    assign accBus[s] = accReg;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= strobes.advance && strobes.frameEnd;
  end

  assign outData = accBus[STAGES-1];

  // R4: idle cycles leave the result untouched
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !strobes.advance |=> $stable(outData));

  // R5: coefficient writes never collide with accepted samples
  assert_coef_idle_R5: assert property (@(posedge clk) disable iff (rst)
    coefWe |-> !strobes.advance);

  if (DECIM > 1) begin : g_pulse_chk
    // R7: results are at least DECIM clocks apart
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
      outValid |=> !outValid);
  end

endmodule

// File: rtl/poly_decim_fir.sv
module poly_decim_fir
  import decim_fir_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 18,
  parameter int DECIM  = 4,
  parameter int STAGES = 4,
  parameter int ACC_W  = 40,
  parameter int ADDR_W = $clog2(DECIM * STAGES)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inSample,
  input  logic                     coefWe,
  input  logic [ADDR_W-1:0]        coefAddr,
  input  logic signed [COEF_W-1:0] coefData,
  output logic                     outValid,
  output logic signed [ACC_W-1:0]  outData
);

  localparam int PHASE_W = (DECIM > 1) ? $clog2(DECIM) : 1;

  mac_ctrl_t          strobes;
  logic [PHASE_W-1:0] phase;

  decim_fir_ctrl #(.DECIM(DECIM), .PHASE_W(PHASE_W)) i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strobes (strobes),
    .phase   (phase)
  );

  decim_fir_dp #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .DECIM(DECIM), .STAGES(STAGES),
    .ACC_W(ACC_W), .PHASE_W(PHASE_W), .ADDR_W(ADDR_W)
  ) i_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .phase    (phase),
    .inSample (inSample),
    .coefWe   (coefWe),
    .coefAddr (coefAddr),
    .coefData (coefData),
    .outValid (outValid),
    .outData  (outData)
  );

endmodule

// File: tb/test_poly_decim_fir.sv
`timescale 1ns/1ps
module test_poly_decim_fir;

  localparam int NS = 32;

  localparam logic signed [17:0] COEF_TAB [16] = '{
    18'sd3, -18'sd7, 18'sd12, 18'sd25, -18'sd40, 18'sd61, 18'sd100, -18'sd131,
    18'sd900, -18'sd1500, 18'sd2047, 18'sd77, -18'sd5, 18'sd19, 18'sd1, -18'sd2 };

  localparam logic signed [15:0] SAMPLE_TAB [NS] = '{
    16'sd100, -16'sd200, 16'sd300, 16'sd1, 16'sd32767, -16'sd32768, 16'sd5, 16'sd0,
    16'sd77, 16'sd78, -16'sd79, 16'sd80, 16'sd1000, 16'sd2000, -16'sd3000, 16'sd4000,
    16'sd9, -16'sd9, 16'sd9, -16'sd9, 16'sd12345, 16'sd0, 16'sd0, -16'sd1,
    16'sd500, 16'sd400, 16'sd300, 16'sd200, -16'sd100, 16'sd50, 16'sd25, 16'sd13 };

  // bit i set: one idle cycle after sample i
  localparam logic [NS-1:0] GAP_MASK = 32'h8421_30A4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic signed [15:0] inSample = '0;
  logic coefWe = 1'b0;
  logic [3:0] coefAddr = '0;
  logic signed [17:0] coefData = '0;
  logic outValid;
  logic signed [39:0] outData;

  int checkCount = 0;
  int failCount = 0;
  int accepted = 0;
  logic lastValid = 1'b0;
  longint prevOut = 0;
  longint hCoef [16];
  longint xHist [128];

  always #2.5 clk = ~clk;

  poly_decim_fir i_poly_decim_fir (
    .clk(clk), .rst(rst), .inValid(inValid), .inSample(inSample),
    .coefWe(coefWe), .coefAddr(coefAddr), .coefData(coefData),
    .outValid(outValid), .outData(outData));

  task automatic check(input string tag, input longint act, input longint exp);
    checkCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint refY(input int n);
    longint acc = 0;
    for (int k = 0; k < 16; k++)
      if (n - k >= 0) acc += hCoef[k] * xHist[n-k];
    return acc;
  endfunction

  // Judge what the previous rising edge produced.
  task automatic checkEdge(input string tag);
    if (lastValid) begin
      int idx = accepted - 1;
      if (idx % 4 == 3) begin
        check("R2 outValid at frame close", longint'(outValid), 1);
        check(tag, longint'(outData), refY(idx - 12));
      end else begin
        check("R2/R7 outValid mid frame", longint'(outValid), 0);
      end
    end else begin
      check("R4 outValid idle", longint'(outValid), 0);
      check("R4 outData idle", longint'(outData), prevOut);
    end
    prevOut = longint'(outData);
  endtask

  task automatic drive(input logic v, input logic signed [15:0] s, input string tag);
    @(negedge clk);
    checkEdge(tag);
    lastValid = v;
    inValid = v;
    inSample = v ? s : 16'sd0;
    if (v) begin
      xHist[accepted] = longint'(s);
      accepted++;
    end
  endtask

  task automatic writeCoef(input int a, input logic signed [17:0] d);
    @(negedge clk);
    coefWe = 1'b1;
    coefAddr = 4'(a);
    coefData = d;
    hCoef[a] = longint'(d);
    @(negedge clk);
    coefWe = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    inValid = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 outValid after reset", longint'(outValid), 0);
    check("R6 outData after reset", longint'(outData), 0);
    rst = 1'b0;
    accepted = 0;
    lastValid = 1'b0;
    prevOut = 0;
    for (int i = 0; i < 128; i++) xHist[i] = 0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) hCoef[i] = 0;
    doReset();

    // R5: load distinct taps, addresses map directly to tap indices
    for (int i = 0; i < 16; i++) writeCoef(i, COEF_TAB[i]);

    // R1/R3/R4: table walk with idle gaps, then flush with zeros
    for (int i = 0; i < NS; i++) begin
      drive(1'b1, SAMPLE_TAB[i], "R1/R3 table output");
      if (GAP_MASK[i]) drive(1'b0, 16'sd0, "R4 gap");
    end
    for (int i = 0; i < 12; i++) drive(1'b1, 16'sd0, "R1/R3 flush output");
    drive(1'b0, 16'sd0, "R4 tail");

    // R6: reset mid-run keeps coefficients, history restarts at zero
    doReset();
    drive(1'b1, 16'sd1000, "R6/R3 impulse response");
    for (int i = 0; i < 23; i++) drive(1'b1, 16'sd0, "R6/R3 impulse response");
    drive(1'b0, 16'sd0, "R4 tail");

    // R8: extreme operands, continuous valid for R7
    doReset();
    for (int i = 0; i < 16; i++) writeCoef(i, -18'sd131072);
    for (int i = 0; i < 28; i++) drive(1'b1, -16'sd32768, "R8 extreme sum");
    drive(1'b0, 16'sd0, "R4 tail");
    check("R8 full-scale value", longint'(outData), 64'sd68719476736);

    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checkCount++;
    failCount++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule